// File: doc/BRIEF.md
# Control Endpoint IN Handshake Controller

This block keeps the control state of the IN direction of endpoint 0 in a full-speed USB device and decides how each IN token is answered. Software programs it through one 32-bit control word: a stall request, a transmit FIFO number, a maximum packet length code, and a pair of one-shot strobes that raise or drop a read-only NAK status. Hardware drops the stall request when a SETUP token arrives on the paired OUT endpoint 0.

Each IN token strobe gives one registered decision a cycle later: STALL, NAK or send-data. STALL beats every NAK source. The local NAK status and a device-wide IN-NAK flag both force NAK. If neither applies, the transmit FIFO status picks send-data or NAK. The block also gives the configured maximum packet length in bytes.

Top module: `ep0_in_ctrl`

## Requirements
- R1: After reset `rd_data` reads 0x0000_8000, `resp_valid` is 0 and `max_pkt_bytes` is 64.
- R2: A write with bit 27 set makes the NAK status (read at bit 17) 1. A write with bit 26 set and bit 27 clear makes it 0. When both are set in one write, the status becomes 1. Bits 27 and 26 always read 0.
- R3: A write to bit 17 on its own, with bits 27 and 26 clear, leaves the NAK status unchanged.
- R4: Bit 21 is the stall request and software writes it directly. An IN token taken while it is 1 is answered with STALL (`resp_code` 2'b10), whatever the NAK status and `glob_in_nak` are.
- R5: A `setup_tok` pulse clears the stall request at that clock edge. A `setup_tok` pulse overrides a write of 1 to bit 21 in the same cycle.
- R6: An IN token is answered with NAK (`resp_code` 2'b01) when the stall request is 0 and either the NAK status or `glob_in_nak` is 1.
- R7: When the stall request, the NAK status and `glob_in_nak` are all 0, an IN token is answered with send-data (`resp_code` 2'b00) if `fifo_pkt_ready` is 1, and with NAK otherwise.
- R8: `resp_valid` is 1 exactly in the cycle after an `in_tok` cycle. The decision uses the state held before that clock edge, so a write or SETUP in the same cycle does not change it. `resp_code` is 2'b00 whenever `resp_valid` is 0.
- R9: Bits 1:0 hold the length code and read back as written. `max_pkt_bytes` is 64, 32, 16 or 8 for codes 00, 01, 10 and 11.
- R10: Bits 25:22 hold the transmit FIFO number and read back as written. Bits 19:18 always read 00 and bit 15 always reads 1. Every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word readback |
| in_tok | input | 1 | One-cycle strobe for an IN token on endpoint 0 |
| setup_tok | input | 1 | One-cycle strobe for a SETUP token on OUT endpoint 0 |
| glob_in_nak | input | 1 | Device-wide IN-NAK flag |
| fifo_pkt_ready | input | 1 | The FIFO holds a complete packet, or a zero-length packet is pending |
| resp_valid | output | 1 | A decision is presented this cycle |
| resp_code | output | 2 | 00 send-data, 01 NAK, 10 STALL |
| max_pkt_bytes | output | 7 | Maximum packet length in bytes |

## Verification
Assertions check on every cycle that:
- a token taken under stall gets STALL, and a token under a NAK source without stall gets NAK;
- SETUP clears the stall request;
- the NAK status moves only on the set and clear strobes;
- the fixed readback fields hold their values;
- a decision appears only after a token.

Some behaviour only the bench scenarios can show:
- the send-data versus NAK choice across all sixteen combinations of stall, NAK status, global NAK and FIFO readiness;
- the length table and the FIFO number readback;
- set-wins-over-clear;
- the decision using the old state when a write lands in the same cycle as a token.

// File: rtl/ep0_in_pkg.sv
package ep0_in_pkg;
  localparam int REG_W     = 32;
  localparam int TXF_W     = 4;
  localparam int MPL_W     = 2;
  localparam int PKT_LEN_W = 7;
  localparam int MAX_PKT   = 64;

  localparam int BIT_SNAK  = 27;
  localparam int BIT_CNAK  = 26;
  localparam int TXF_LSB   = 22;
  localparam int BIT_STALL = 21;
  localparam int TYPE_LSB  = 18;
  localparam int BIT_NAKS  = 17;
  localparam int BIT_ACT   = 15;
  localparam int MPL_LSB   = 0;

  localparam logic [REG_W-1:0] WR_USED_MASK =
      (REG_W'(1) << BIT_SNAK) | (REG_W'(1) << BIT_CNAK) |
      (REG_W'((1 << TXF_W) - 1) << TXF_LSB) | (REG_W'(1) << BIT_STALL) |
      (REG_W'((1 << MPL_W) - 1) << MPL_LSB);

  typedef enum logic [1:0] {
    RESP_DATA  = 2'b00,
    RESP_NAK   = 2'b01,
    RESP_STALL = 2'b10
  } resp_e;

  typedef struct packed {
    logic             stall;
    logic             naks;
    logic [TXF_W-1:0] txf;
    logic [MPL_W-1:0] mpl;
  } ep0_state_t;

  function automatic logic [PKT_LEN_W-1:0] mpl_to_bytes(input logic [MPL_W-1:0] code);
    return PKT_LEN_W'(MAX_PKT) >> code;
  endfunction

  function automatic resp_e decide(input logic stall, input logic naks,
                                   input logic gnak, input logic ready);
    if (stall)          return RESP_STALL;
    else if (naks || gnak) return RESP_NAK;
    else if (ready)     return RESP_DATA;
    else                return RESP_NAK;
  endfunction

  function automatic logic [REG_W-1:0] pack_readback(input ep0_state_t s);
    logic [REG_W-1:0] w;
    w = '0;
    w[TXF_LSB +: TXF_W]  = s.txf;
    w[BIT_STALL]         = s.stall;
    w[TYPE_LSB +: 2]     = 2'b00;
    w[BIT_NAKS]          = s.naks;
    w[BIT_ACT]           = 1'b1;
    w[MPL_LSB +: MPL_W]  = s.mpl;
    return w;
  endfunction
endpackage

// File: rtl/ep0_ctrl_regs.sv
module ep0_ctrl_regs
  import ep0_in_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             setup_tok,
  output ep0_state_t       st,
  output logic             nak_set_ev,
  output logic             nak_clr_ev,
  output logic             stall_clr_ev
);
  logic unused_wr_bits;
  assign unused_wr_bits = ^(wr_data & ~WR_USED_MASK);

  // set strobe takes precedence over clear strobe
  assign nak_set_ev   = wr_en & wr_data[BIT_SNAK];
  assign nak_clr_ev   = wr_en & wr_data[BIT_CNAK] & ~wr_data[BIT_SNAK];
  assign stall_clr_ev = setup_tok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= '0;
    end else begin
      if (wr_en) begin
        st.txf <= wr_data[TXF_LSB +: TXF_W];
        st.mpl <= wr_data[MPL_LSB +: MPL_W];
      end
      if (stall_clr_ev)  st.stall <= 1'b0;
      else if (wr_en)    st.stall <= wr_data[BIT_STALL];
      if (nak_set_ev)      st.naks <= 1'b1;
      else if (nak_clr_ev) st.naks <= 1'b0;
    end
  end
endmodule

// File: rtl/ep0_resp_arb.sv
module ep0_resp_arb
  import ep0_in_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_tok,
  input  logic       stall,
  input  logic       naks,
  input  logic       gnak,
  input  logic       ready,
  output logic       resp_valid,
  output logic [1:0] resp_code
);
  resp_e next_code;
  assign next_code = decide(stall, naks, gnak, ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_code  <= RESP_DATA;
    end else begin
      resp_valid <= in_tok;
      resp_code  <= in_tok ? next_code : RESP_DATA;
    end
  end
endmodule

// File: rtl/ep0_rd_pack.sv
module ep0_rd_pack
  import ep0_in_pkg::*;
(
  input  ep0_state_t           st,
  output logic [REG_W-1:0]     rd_data,
  output logic [PKT_LEN_W-1:0] max_pkt_bytes
);
  assign rd_data       = pack_readback(st);
  assign max_pkt_bytes = mpl_to_bytes(st.mpl);
endmodule

// File: rtl/ep0_in_ctrl.sv
module ep0_in_ctrl
  import ep0_in_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_W-1:0]     wr_data,
  output logic [REG_W-1:0]     rd_data,
  input  logic                 in_tok,
  input  logic                 setup_tok,
  input  logic                 glob_in_nak,
  input  logic                 fifo_pkt_ready,
  output logic                 resp_valid,
  output logic [1:0]           resp_code,
  output logic [PKT_LEN_W-1:0] max_pkt_bytes
);
  ep0_state_t st;
  logic stall_q, naks_q;
  logic nak_set_ev, nak_clr_ev, stall_clr_ev;

  ep0_ctrl_regs u_regs (
    .clk, .rst_n, .wr_en, .wr_data, .setup_tok,
    .st, .nak_set_ev, .nak_clr_ev, .stall_clr_ev
  );

  assign stall_q = st.stall;
  assign naks_q  = st.naks;

  ep0_resp_arb u_arb (
    .clk, .rst_n, .in_tok,
    .stall(stall_q), .naks(naks_q), .gnak(glob_in_nak), .ready(fifo_pkt_ready),
    .resp_valid, .resp_code
  );

  ep0_rd_pack u_pack (
    .st, .rd_data, .max_pkt_bytes
  );
endmodule

// File: rtl/ep0_in_ctrl_chk.sv
module ep0_in_ctrl_chk
  import ep0_in_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [REG_W-1:0]     wr_data,
  input logic [REG_W-1:0]     rd_data,
  input logic                 in_tok,
  input logic                 setup_tok,
  input logic                 glob_in_nak,
  input logic                 fifo_pkt_ready,
  input logic                 resp_valid,
  input logic [1:0]           resp_code,
  input logic [PKT_LEN_W-1:0] max_pkt_bytes,
  input logic                 stall_q,
  input logic                 naks_q,
  input logic                 nak_set_ev,
  input logic                 nak_clr_ev,
  input logic                 stall_clr_ev
);
  logic unused_chk;
  assign unused_chk = ^{fifo_pkt_ready, nak_clr_ev, stall_clr_ev};

  assert_stall_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tok && stall_q) |=> (resp_valid && resp_code == 2'b10));

  assert_nak_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tok && !stall_q && (naks_q || glob_in_nak)) |=> (resp_valid && resp_code == 2'b01));

  assert_setup_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    setup_tok |=> !rd_data[BIT_STALL]);

  assert_nak_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    nak_set_ev |=> rd_data[BIT_NAKS]);

  assert_nak_strobe_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_data[BIT_SNAK] || wr_data[BIT_CNAK])) |=> $stable(naks_q));

  assert_resp_follows_tok_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(in_tok));

  assert_idle_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> resp_code == 2'b00);

  assert_fixed_fields_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[BIT_ACT] && rd_data[TYPE_LSB +: 2] == 2'b00 &&
    rd_data[31:28] == 4'h0 && rd_data[BIT_SNAK] == 1'b0 && rd_data[BIT_CNAK] == 1'b0 &&
    rd_data[20] == 1'b0 && rd_data[16] == 1'b0 && rd_data[14:2] == '0);

  assert_len_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(max_pkt_bytes) == 1 && max_pkt_bytes >= PKT_LEN_W'(8));
endmodule

bind ep0_in_ctrl ep0_in_ctrl_chk u_chk (.*);

// File: tb/tb_ep0_in_ctrl.sv
module tb_ep0_in_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        in_tok = 1'b0;
  logic        setup_tok = 1'b0;
  logic        glob_in_nak = 1'b0;
  logic        fifo_pkt_ready = 1'b0;
  logic        resp_valid;
  logic [1:0]  resp_code;
  logic [6:0]  max_pkt_bytes;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ep0_in_ctrl dut (
    .clk, .rst_n, .wr_en, .wr_data, .rd_data, .in_tok, .setup_tok,
    .glob_in_nak, .fifo_pkt_ready, .resp_valid, .resp_code, .max_pkt_bytes
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // readback word assembled independently
  function automatic logic [31:0] exp_word(bit stall, bit naks, int txf, int mpl);
    return 32'h0000_8000 + (stall ? 32'h0020_0000 : 0) + (naks ? 32'h0002_0000 : 0)
           + 32'(txf) * 32'h0040_0000 + 32'(mpl);
  endfunction

  function automatic logic [1:0] exp_resp(bit stall, bit naks, bit gnak, bit rdy);
    if (stall) return 2'd2;
    if (naks || gnak) return 2'd1;
    return rdy ? 2'd0 : 2'd1;
  endfunction

  task automatic write(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic token(output logic [1:0] code, output logic vld);
    in_tok = 1'b1;
    @(negedge clk);
    in_tok = 1'b0;
    code = resp_code; vld = resp_valid;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] c;
    logic v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 rd_data", rd_data, 32'h0000_8000);
    check("R1 resp_valid", {31'b0, resp_valid}, 0);
    check("R1 max_pkt", {25'b0, max_pkt_bytes}, 64);

    // R2/R4/R6/R7 sweep of stall, nak status, global nak, fifo ready
    for (int i = 0; i < 16; i++) begin
      bit s, n, g, f;
      s = i[3]; n = i[2]; g = i[1]; f = i[0];
      write((s ? 32'h0020_0000 : 0) | (n ? 32'h0800_0000 : 32'h0400_0000));
      check("R2 naks readback", rd_data, exp_word(s, n, 0, 0));
      glob_in_nak = g; fifo_pkt_ready = f;
      token(c, v);
      check("R8 resp_valid after token", {31'b0, v}, 1);
      check(s ? "R4 stall resp" : ((n | g) ? "R6 nak resp" : "R7 fifo resp"),
            {30'b0, c}, {30'b0, exp_resp(s, n, g, f)});
      @(negedge clk);
      check("R8 resp_valid drops", {30'b0, resp_valid, resp_code[0] | resp_code[1]}, 0);
    end
    glob_in_nak = 0; fifo_pkt_ready = 1;

    // R2 set wins over clear; strobe bits read 0
    write(32'h0C00_0000);
    check("R2 set wins", rd_data, exp_word(0, 1, 0, 0));
    write(32'h0400_0000);
    check("R2 clear", rd_data, exp_word(0, 0, 0, 0));

    // R3 direct write of bit 17 ignored; observed via readback and response
    write(32'h0002_0000);
    check("R3 naks unchanged (0)", rd_data, exp_word(0, 0, 0, 0));
    token(c, v);
    check("R3 response stays data", {30'b0, c}, 0);
    write(32'h0800_0000);
    write(32'h0000_0000);
    check("R3 naks unchanged (1)", rd_data, exp_word(0, 1, 0, 0));
    write(32'h0400_0000);

    // R5 SETUP clears stall; SETUP beats same-cycle write
    write(32'h0020_0000);
    check("R5 stall set", rd_data, exp_word(1, 0, 0, 0));
    setup_tok = 1; @(negedge clk); setup_tok = 0;
    check("R5 setup clears", rd_data, exp_word(0, 0, 0, 0));
    setup_tok = 1; write(32'h0020_0000); setup_tok = 0;
    check("R5 setup beats write", rd_data, exp_word(0, 0, 0, 0));
    token(c, v);
    check("R5 data after clear", {30'b0, c}, 0);

    // R8 token with same-cycle write uses old state
    wr_en = 1; wr_data = 32'h0020_0000;
    token(c, v);
    wr_en = 0; wr_data = 0;
    check("R8 old state used", {30'b0, c}, 0);
    token(c, v);
    check("R8 new state next token", {30'b0, c}, 2);
    // token with same-cycle setup still answered STALL
    setup_tok = 1;
    token(c, v);
    setup_tok = 0;
    check("R8 setup same cycle stall", {30'b0, c}, 2);
    check("R5 stall cleared", rd_data, exp_word(0, 0, 0, 0));

    // R9 length codes, R10 fifo number sweep
    for (int t = 0; t < 16; t++) begin
      for (int m = 0; m < 4; m++) begin
        write(32'(t) << 22 | 32'(m));
        check("R10 txf readback", rd_data, exp_word(0, 0, t, m));
        check("R9 length", {25'b0, max_pkt_bytes}, 32'(64 / (1 << m)));
      end
    end

    // R10 all-ones write: reserved stay 0, fixed fields hold
    write(32'hFFFF_FFFF);
    check("R10 all ones", rd_data, 32'h03E2_8003);
    write(32'h0400_0000);
    check("R10 all zero", rd_data, 32'h0000_8000);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule